// File: doc/BRIEF.md
# Double-Word by Word Divider

This block divides a two-word dividend by a one-word divisor. It returns a one-word quotient and a one-word remainder. The dividend is given as a high word and a low word. The block joins them into one double-width value, with the high word in the upper half. A mode input chooses between unsigned operands and two's complement operands. It is sampled, together with the operands, in the cycle that a start request is accepted.

The division runs on an iterative restoring core. The core makes one quotient bit per clock and always builds the full double-width quotient. Afterwards a range stage decides whether the true quotient fits in one word. That test uses the unsigned word range or the signed word range, depending on the mode. A zero divisor and an out-of-range quotient both raise the divide-error output on the completion pulse. In that case the quotient and remainder outputs keep their previous contents. On success both outputs update in the same cycle as the completion pulse. No arithmetic status flags are produced.

The block is used as a start/busy/done unit. A start pulse while the unit is idle begins a division. Busy then stays high until the completion cycle. Start pulses that arrive while busy is high are ignored.

Top module: `dword_divider`

## Requirements
- R1: The dividend is the double-width value {dividend_hi, dividend_lo}, with dividend_hi in the upper word.
- R2: In unsigned mode (signed_mode = 0), when the divisor is nonzero and the quotient is at most 0xFFFF, quotient and remainder take the truncated quotient and the remainder of the unsigned division.
- R3: In unsigned mode, a quotient above 0xFFFF raises div_error, and quotient and remainder keep their previous values.
- R4: A zero divisor raises div_error in either mode, and quotient and remainder keep their previous values.
- R5: In signed mode (signed_mode = 1), the dividend and the divisor are two's complement. The quotient truncates toward zero. A nonzero remainder takes the sign of the dividend.
- R6: In signed mode, a true quotient outside -32768..32767 raises div_error and keeps the outputs unchanged. The quotients -32768 and 32767 themselves are delivered without error.
- R7: A start accepted at clock edge k gives done = 1 for exactly one cycle, right after edge k+33 (two cycles per word bit plus one). busy is high from edge k until edge k+33, and it is low while done is high.
- R8: div_error is high only together with done. On a successful completion, quotient and remainder change only in the done cycle.
- R9: start is accepted only while busy is low, which includes the done cycle. Start pulses and operand or mode changes while busy is high have no effect on the running division.
- R10: During reset, busy, done and div_error are 0, and quotient and remainder are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division with the current operands |
| signed_mode | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_hi | input | 16 | Upper word of the dividend |
| dividend_lo | input | 16 | Lower word of the dividend |
| divisor | input | 16 | Divisor word |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| div_error | output | 1 | Zero divisor or quotient out of range, valid with done |
| quotient | output | 16 | Last successfully committed quotient |
| remainder | output | 16 | Last successfully committed remainder |

## Verification
The bound checker watches the handshake on every cycle. It checks that done lasts one cycle and comes at the fixed distance from the accepted start, that busy is low during done, and that div_error appears only with done. It also checks that the outputs move only in a done cycle without error, and that a zero divisor captured at acceptance always ends in an error. The arithmetic itself can only be shown by the bench's scenarios, which a reference model scores on each clock. These include unsigned overflow such as 0xFFFFFFFF / 1, the signed range edges -32768 and 32767, signed results from negative dividends and negative divisors, operand changes and extra start pulses during a division, and a start held high across the done cycle.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;

  typedef enum logic [1:0] {
    CORE_IDLE = 2'd0,
    CORE_RUN  = 2'd1,
    CORE_FIN  = 2'd2
  } core_state_e;

  // Per-division context captured at acceptance
  typedef struct packed {
    logic signed_op;
    logic neg_quo;
    logic neg_rem;
    logic zero_div;
  } div_ctx_t;

endpackage

// File: rtl/div_operand_prep.sv
`timescale 1ns/1ps
module div_operand_prep #(
  parameter int unsigned DW = 16
) (
  input  logic                  signed_mode,
  input  logic [DW-1:0]         word_hi,
  input  logic [DW-1:0]         word_lo,
  input  logic [DW-1:0]         dvsr,
  output logic [2*DW-1:0]       num_mag,
  output logic [DW-1:0]         den_mag,
  output div_pkg::div_ctx_t     ctx
);
  localparam int unsigned NW = 2*DW;
  localparam logic [NW-1:0] ONE_N = {{(NW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ONE_D = {{(DW-1){1'b0}}, 1'b1};

  logic [NW-1:0] num_raw;
  logic          num_neg;
  logic          den_neg;

  always_comb begin
    num_raw      = {word_hi, word_lo};
    num_neg      = signed_mode & num_raw[NW-1];
    den_neg      = signed_mode & dvsr[DW-1];
    num_mag      = num_neg ? ((~num_raw) + ONE_N) : num_raw;
    den_mag      = den_neg ? ((~dvsr) + ONE_D) : dvsr;
    ctx.signed_op = signed_mode;
    ctx.neg_quo   = num_neg ^ den_neg;
    ctx.neg_rem   = num_neg;
    ctx.zero_div  = (dvsr == '0);
  end

endmodule

// File: rtl/div_restore_core.sv
`timescale 1ns/1ps
module div_restore_core #(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2*DW-1:0]   num_mag,
  input  logic [DW-1:0]     den_mag,
  output logic              busy,
  output logic              fin,
  output logic [2*DW-1:0]   quo_mag,
  output logic [DW-1:0]     rem_mag
);
  import div_pkg::*;

  localparam int unsigned NW   = 2*DW;
  localparam int unsigned CW   = $clog2(NW);
  localparam logic [CW-1:0] LAST = CW'(NW-1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  core_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] acc_q, acc_d;
  logic [DW-1:0] part_q, part_d;
  logic [DW-1:0] den_q, den_d;
  logic          dp_en;
  logic          den_en;

  // One restoring step: shift in the next dividend bit, try to subtract
  logic [DW:0]   shifted;
  logic [DW+1:0] trial;
  logic          take;
  logic [DW-1:0] part_step;
  logic [NW-1:0] acc_step;

  always_comb begin
    shifted   = {part_q, acc_q[NW-1]};
    trial     = {1'b0, shifted} - {2'b00, den_q};
    take      = ~trial[DW+1];
    part_step = take ? trial[DW-1:0] : shifted[DW-1:0];
    acc_step  = {acc_q[NW-2:0], take};
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    part_d  = part_q;
    den_d   = den_q;
    dp_en   = 1'b0;
    den_en  = 1'b0;
    unique case (state_q)
      CORE_IDLE: begin
        if (load) begin
          state_d = CORE_RUN;
          cnt_d   = '0;
          acc_d   = num_mag;
          part_d  = '0;
          den_d   = den_mag;
          dp_en   = 1'b1;
          den_en  = 1'b1;
        end
      end
      CORE_RUN: begin
        acc_d  = acc_step;
        part_d = part_step;
        cnt_d  = cnt_q + ONE_C;
        dp_en  = 1'b1;
        if (cnt_q == LAST) begin
          state_d = CORE_FIN;
        end
      end
      CORE_FIN: begin
        state_d = CORE_IDLE;
      end
      default: begin
        state_d = CORE_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CORE_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
      part_q  <= '0;
      den_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (dp_en) begin
        acc_q  <= acc_d;
        part_q <= part_d;
      end
      if (den_en) begin
        den_q <= den_d;
      end
    end
  end

  assign busy    = (state_q != CORE_IDLE);
  assign fin     = (state_q == CORE_FIN);
  assign quo_mag = acc_q;
  assign rem_mag = part_q;

endmodule

// File: rtl/div_range_check.sv
`timescale 1ns/1ps
module div_range_check #(
  parameter int unsigned DW = 16
) (
  input  div_pkg::div_ctx_t ctx,
  input  logic [2*DW-1:0]   quo_mag,
  input  logic [DW-1:0]     rem_mag,
  output logic              err,
  output logic [DW-1:0]     quo_word,
  output logic [DW-1:0]     rem_word
);
  localparam int unsigned NW = 2*DW;
  localparam logic [DW-1:0] ONE_D   = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  logic          upper_zero;
  logic [DW-1:0] low_mag;
  logic          fits;

  always_comb begin
    upper_zero = (quo_mag[NW-1:DW] == '0);
    low_mag    = quo_mag[DW-1:0];
    if (!ctx.signed_op) begin
      fits = upper_zero;
    end else if (ctx.neg_quo) begin
      fits = upper_zero && (low_mag <= NEG_LIM);
    end else begin
      fits = upper_zero && !low_mag[DW-1];
    end
    err      = ctx.zero_div | ~fits;
    quo_word = ctx.neg_quo ? ((~low_mag) + ONE_D) : low_mag;
    rem_word = ctx.neg_rem ? ((~rem_mag) + ONE_D) : rem_mag;
  end

endmodule

// File: rtl/dword_divider.sv
`timescale 1ns/1ps
module dword_divider #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          signed_mode,
  input  logic [DW-1:0] dividend_hi,
  input  logic [DW-1:0] dividend_lo,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic          div_error,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder
);
  import div_pkg::*;

  localparam int unsigned NW = 2*DW;

  logic [NW-1:0] num_mag;
  logic [DW-1:0] den_mag;
  div_ctx_t      ctx_d, ctx_live, ctx_q;
  logic          ctx_en;
  logic          accept;

  logic          core_busy;
  logic          core_fin;
  logic [NW-1:0] quo_mag;
  logic [DW-1:0] rem_mag;

  logic          chk_err;
  logic [DW-1:0] quo_word;
  logic [DW-1:0] rem_word;

  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [DW-1:0] rem_q, rem_d;
  logic          res_en;

  div_operand_prep #(.DW(DW)) u_prep (
    .signed_mode (signed_mode),
    .word_hi     (dividend_hi),
    .word_lo     (dividend_lo),
    .dvsr        (divisor),
    .num_mag     (num_mag),
    .den_mag     (den_mag),
    .ctx         (ctx_live)
  );

  div_restore_core #(.DW(DW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .num_mag (num_mag),
    .den_mag (den_mag),
    .busy    (core_busy),
    .fin     (core_fin),
    .quo_mag (quo_mag),
    .rem_mag (rem_mag)
  );

  div_range_check #(.DW(DW)) u_range (
    .ctx      (ctx_q),
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .err      (chk_err),
    .quo_word (quo_word),
    .rem_word (rem_word)
  );

  always_comb begin
    accept = start & ~core_busy;
    ctx_en = accept;
    ctx_d  = ctx_live;
    done_d = core_fin;
    err_d  = core_fin & chk_err;
    res_en = core_fin & ~chk_err;
    quo_d  = quo_word;
    rem_d  = rem_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      if (ctx_en) begin
        ctx_q <= ctx_d;
      end
      done_q <= done_d;
      err_q  <= err_d;
      if (res_en) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
      end
    end
  end

  assign busy      = core_busy;
  assign done      = done_q;
  assign div_error = err_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/dword_divider_chk.sv
`timescale 1ns/1ps
module dword_divider_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          div_error,
  input logic [DW-1:0] divisor,
  input logic [DW-1:0] quotient,
  input logic [DW-1:0] remainder
);
  localparam int unsigned LAT  = 2*DW + 2;
  localparam int unsigned CNTW = $clog2(LAT + 2);
  localparam logic [CNTW-1:0] LAT_C = CNTW'(LAT);
  localparam logic [CNTW-1:0] SAT_C = CNTW'(LAT + 1);
  localparam logic [CNTW-1:0] ONE_C = CNTW'(1);

  logic [CNTW-1:0] since_q;
  logic            zero_cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= '0;
      zero_cap_q <= 1'b0;
    end else if (start && !busy) begin
      since_q    <= ONE_C;
      zero_cap_q <= (divisor == '0);
    end else if (since_q != '0 && since_q != SAT_C) begin
      since_q <= since_q + ONE_C;
    end
  end

  a_r8_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_error |-> done);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_q == LAT_C));

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_outputs_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  a_r3_error_holds_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    div_error |-> ($stable(quotient) && $stable(remainder)));

  a_r4_zero_div_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_cap_q) |-> div_error);

endmodule

bind dword_divider dword_divider_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .div_error (div_error),
  .divisor   (divisor),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/dword_divider_tb.sv
`timescale 1ns/1ps
module dword_divider_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [15:0] dividend_hi = '0;
  logic [15:0] dividend_lo = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, div_error;
  logic [15:0] quotient, remainder;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  dword_divider u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .dividend_hi (dividend_hi),
    .dividend_lo (dividend_lo),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .div_error   (div_error),
    .quotient    (quotient),
    .remainder   (remainder)
  );

  // Reference model state
  int          m_cd = 0;
  bit          m_busy = 0, m_done = 0, m_err = 0;
  logic [15:0] m_q = '0, m_r = '0;
  bit          p_err = 0;
  logic [15:0] p_q = '0, p_r = '0;

  function automatic void ref_div(input logic [15:0] h, l, d, input bit s,
                                  output bit e, output logic [15:0] q, r);
    longint n, dv, qq, rr;
    n  = s ? longint'($signed({h, l})) : longint'({h, l});
    dv = s ? longint'($signed(d)) : longint'(d);
    q = '0; r = '0;
    if (dv == 0) begin
      e = 1;
    end else begin
      qq = n / dv;
      rr = n % dv;
      if (s) e = (qq < -32768) || (qq > 32767);
      else   e = (qq > 65535);
      q = qq[15:0];
      r = rr[15:0];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cd = 0; m_busy = 0; m_done = 0; m_err = 0; m_q = '0; m_r = '0;
    end else begin
      m_done = 0;
      m_err  = 0;
      if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin
          m_busy = 0;
          m_done = 1;
          m_err  = p_err;
          if (!p_err) begin
            m_q = p_q;
            m_r = p_r;
          end
        end
      end else if (start) begin
        ref_div(dividend_hi, dividend_lo, divisor, signed_mode, p_err, p_q, p_r);
        m_cd   = 33;
        m_busy = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [15:0] act, exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    chk(busy == m_busy, "busy", {15'd0, busy}, {15'd0, m_busy});
    chk(done == m_done, "done", {15'd0, done}, {15'd0, m_done});
    chk(div_error == m_err, "div_error", {15'd0, div_error}, {15'd0, m_err});
    chk(quotient == m_q, "quotient", quotient, m_q);
    chk(remainder == m_r, "remainder", remainder, m_r);
  end

  // One division; operands and mode are scrambled and start is pulsed again
  // while busy, which must have no effect (R9)
  task automatic run_div(input logic [15:0] h, l, d, input bit s, input string tag);
    @(negedge clk);
    cur_req = tag;
    start = 1'b1; dividend_hi = h; dividend_lo = l; divisor = d; signed_mode = s;
    @(negedge clk);
    start = 1'b0; dividend_hi = ~h; dividend_lo = l ^ 16'h5A5A; divisor = d + 16'd3;
    signed_mode = ~s;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; divisor = 16'd0;
    repeat (32) @(negedge clk);
  endtask

  initial begin
    #500000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 word order of the dividend
    run_div(16'h0001, 16'h0000, 16'h0002, 1'b0, "R1");
    run_div(16'h0000, 16'h0001, 16'h0001, 1'b0, "R1");
    // R2 unsigned results that fit
    run_div(16'h0012, 16'h3456, 16'h1234, 1'b0, "R2");
    run_div(16'h0000, 16'hFFFF, 16'h00FF, 1'b0, "R2");
    run_div(16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0, "R2 R7");
    // R3 unsigned overflow keeps previous outputs
    run_div(16'hFFFF, 16'hFFFF, 16'h0001, 1'b0, "R3 R8");
    run_div(16'h1234, 16'h0000, 16'h1234, 1'b0, "R3");
    // R4 zero divisor in both modes
    run_div(16'h0000, 16'h0005, 16'h0000, 1'b0, "R4");
    run_div(16'hFFFF, 16'hFFF0, 16'h0000, 1'b1, "R4");
    // R5 signed truncation and remainder sign
    run_div(16'hFFFF, 16'hFFF9, 16'h0002, 1'b1, "R5");
    run_div(16'h0000, 16'h0007, 16'hFFFE, 1'b1, "R5");
    run_div(16'hFFFF, 16'hFFF9, 16'hFFFE, 1'b1, "R5");
    run_div(16'hFFFF, 16'hFFFF, 16'h0001, 1'b1, "R5");
    // R6 signed range edges
    run_div(16'hFFFF, 16'h0000, 16'h0002, 1'b1, "R6");
    run_div(16'h0000, 16'hFFFE, 16'h0002, 1'b1, "R6");
    run_div(16'hFFFF, 16'h0000, 16'hFFFE, 1'b1, "R6");
    run_div(16'h8000, 16'h0000, 16'hFFFF, 1'b1, "R6");
    run_div(16'h0000, 16'h8000, 16'h0001, 1'b1, "R6");
    // R9 extra start pulses and operand changes while busy
    run_div(16'h0003, 16'h0000, 16'h0007, 1'b0, "R9");

    // R7 R9 start held high: second division accepted in the done cycle
    @(negedge clk);
    cur_req = "R7 R9";
    start = 1'b1; signed_mode = 1'b0;
    dividend_hi = 16'h0000; dividend_lo = 16'h0064; divisor = 16'h0009;
    repeat (40) @(negedge clk);
    dividend_lo = 16'h00C8; divisor = 16'h000B;
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule